// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block turns single CPU bus requests into DRAM strobe sequences. A request carries a linear address and a direction. The controller splits the address into a row part and a column part at a boundary of 8, 9 or 10 bits. It then drives the row address low with the row strobe (RAS) and the column address low with the column strobe (CAS). When multiplexing is off, the full linear address stays on the address pins for the whole access. When it is on, the row and column parts take turns on the same pins.

With burst operation enabled, the controller remembers the row of the last access and keeps RAS low between accesses. A later request to the same row skips the row phase and runs only a column cycle. A request to a different row first raises RAS for a fixed precharge and then runs a full access. One column cycle is 20 clock cycles long. CAS is high for the first 50% or the first 35% of it and low for the rest. The CPU sees `ready` on the last low cycle of CAS.

A small configuration word sets the mode. Write it only while no access is in progress.

Top module: `dram_page_ctrl`

## Requirements
- R1: During and right after reset, `ras_n`, `cas_n` and `dram_we_n` are 1 and `ready` is 0. The configuration word resets to all zeros. Its fields are: bit 4 burst enable, bit 3 short CAS-high select, bit 2 multiplex enable, bits 1:0 shift code.
- R2: With burst enable 0, every access is a full access with no row compare. RAS falls on the cycle after the accepting edge. There are 2 row-phase cycles, then a 20-cycle column phase. `ready` is seen 22 cycles after the accepting edge.
- R3: With burst enable 1, a request whose row matches the stored row (page still open) runs only the column phase. RAS stays low throughout, no row phase is driven, and `ready` is seen 20 cycles after acceptance.
- R4: With burst enable 1, a request to a different row while the page is open raises RAS for exactly 2 cycles and then runs a full access. `ready` is seen 24 cycles after acceptance.
- R5: The compared row is the address shifted right by S. S is 8, 9 or 10 for shift code 00, 01 or 10, and code 11 acts as 10. This holds whether multiplexing is on or off.
- R6: With multiplex enable 0, `dram_addr` equals the full request address during both the row phase and the column phase.
- R7: With multiplex enable 1, `dram_addr` is the request address shifted right by S during the row phase. During the column phase it is the low S bits of the address, with the upper bits 0.
- R8: In the column phase, `cas_n` is 1 for the first 10 cycles (short select 0) or the first 7 cycles (short select 1). It is 0 for the remaining cycles of the 20, so it is low for 10 or 13 cycles.
- R9: `ready` is 1 for exactly one cycle, which is the last cycle with `cas_n` low. On the next cycle `cas_n` is 1 and `ready` is 0.
- R10: Any configuration write forgets the stored row. The next access is full, with the 2-cycle precharge first if the page is open, even when its row matches.
- R11: `dram_we_n` is 0 for every cycle of the column phase of a write and 1 for every cycle of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration word (burst, short CAS high, multiplex, shift code) |
| req | input | 1 | CPU request, held until `ready` |
| req_addr | input | ADDR_W | CPU linear address |
| req_write | input | 1 | 1 for write, 0 for read |
| ready | output | 1 | One-cycle completion pulse |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | DRAM address pins |

## Verification
The bench measures access length, RAS-high cycles and CAS-low cycles at the ports. A design that ignored the stored row, compared the wrong bits, or skipped the precharge would show 22 or 24 cycles where 20, 22 or 24 are due. Addresses are chosen to differ only in bit 8 or bit 9, so a wrong compare boundary turns a hit into a miss or the reverse. The reserved shift code and the multiplexed row and column values are checked for every code, which catches a design that drops a shift bit. The bench also repeats an access right after a configuration write, so a design that keeps a stale row would wrongly run a 20-cycle hit there.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL
    } dpc_state_e;

    // Field order follows the written word: bit 4 down to bit 0.
    typedef struct packed {
        logic       burst;
        logic       cas_short;
        logic       mux;
        logic [1:0] shift_code;
    } dpc_cfg_t;

    localparam int CFG_W = 5;

    // Row/column split point; code 11 is reserved and acts as 10.
    function automatic logic [3:0] split_bits(input logic [1:0] code);
        case (code)
            2'b00:   split_bits = 4'd8;
            2'b01:   split_bits = 4'd9;
            default: split_bits = 4'd10;
        endcase
    endfunction

endpackage

// File: rtl/dpc_cfg_reg.sv
module dpc_cfg_reg
    import dpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output dpc_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            cfg <= dpc_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/dpc_row_track.sv
module dpc_row_track #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              forget,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_row,
    input  logic [ADDR_W-1:0] probe_row,
    output logic              hit
);
    logic [ADDR_W-1:0] kept_row;
    logic              kept_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            kept_row <= '0;
            kept_ok  <= 1'b0;
        end else if (forget) begin
            kept_ok  <= 1'b0;
        end else if (load) begin
            kept_row <= load_row;
            kept_ok  <= 1'b1;
        end
    end

    assign hit = kept_ok && (kept_row == probe_row);
endmodule

// File: rtl/dpc_cas_timer.sv
module dpc_cas_timer #(
    parameter int COL_TICKS = 20,
    parameter int HI_HALF   = 10,
    parameter int HI_SHORT  = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic short_hi,
    output logic cas_n,
    output logic last
);
    localparam int TICK_W = $clog2(COL_TICKS);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(COL_TICKS - 1);

    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] hi_len;

    assign hi_len = short_hi ? TICK_W'(HI_SHORT) : TICK_W'(HI_HALF);
    assign last   = run && (tick == LAST_TICK);
    assign cas_n  = !run || (tick < hi_len);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick <= '0;
        end else if (last) begin
            tick <= '0;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dpc_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int PRE_CYC   = 2,
    parameter int ROW_CYC   = 2,
    parameter int COL_TICKS = 20,
    parameter int HI_HALF   = 10,
    parameter int HI_SHORT  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              ready,
    output logic              ras_n,
    output logic              cas_n,
    output logic              dram_we_n,
    output logic [ADDR_W-1:0] dram_addr
);
    localparam int PH_MAX = (PRE_CYC > ROW_CYC) ? PRE_CYC : ROW_CYC;
    localparam int CNT_W  = $clog2(PH_MAX + 1);
    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] ROW_LAST = CNT_W'(ROW_CYC - 1);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;

    dpc_cfg_t          cfg_q;
    dpc_state_e        state;
    logic [CNT_W-1:0]  ph_cnt;
    logic              page_open;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [3:0]        split;
    logic [ADDR_W-1:0] col_mask;
    logic [ADDR_W-1:0] row_of_q;
    logic              row_hit;
    logic              col_run;
    logic              col_last;
    logic              mux_on;

    dpc_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    assign split    = split_bits(cfg_q.shift_code);
    assign col_mask = ~(ALL_ONES << split);
    assign row_of_q = addr_q >> split;
    assign mux_on   = cfg_q.mux;

    dpc_row_track #(.ADDR_W(ADDR_W)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .forget    (cfg_we),
        .load      (state == ST_ROW),
        .load_row  (row_of_q),
        .probe_row (req_addr >> split),
        .hit       (row_hit)
    );

    assign col_run = (state == ST_COL);

    dpc_cas_timer #(
        .COL_TICKS (COL_TICKS),
        .HI_HALF   (HI_HALF),
        .HI_SHORT  (HI_SHORT)
    ) u_cas (
        .clk      (clk),
        .rst      (rst),
        .run      (col_run),
        .short_hi (cfg_q.cas_short),
        .cas_n    (cas_n),
        .last     (col_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ph_cnt    <= '0;
            page_open <= 1'b0;
            addr_q    <= '0;
            write_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        ph_cnt  <= '0;
                        if (cfg_q.burst && page_open && row_hit) begin
                            state <= ST_COL;
                        end else if (page_open) begin
                            state     <= ST_PRE;
                            page_open <= 1'b0;
                        end else begin
                            state <= ST_ROW;
                        end
                    end
                end
                ST_PRE: begin
                    if (ph_cnt == PRE_LAST) begin
                        ph_cnt <= '0;
                        state  <= ST_ROW;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                ST_ROW: begin
                    if (ph_cnt == ROW_LAST) begin
                        ph_cnt <= '0;
                        state  <= ST_COL;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                ST_COL: begin
                    if (col_last) begin
                        state     <= ST_IDLE;
                        page_open <= cfg_q.burst;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ras_n     = !((state == ST_ROW) || (state == ST_COL) ||
                         ((state == ST_IDLE) && page_open));
    assign ready     = col_last;
    assign dram_we_n = !(write_q && col_run);

    always_comb begin
        case (state)
            ST_ROW:  dram_addr = cfg_q.mux ? row_of_q : addr_q;
            ST_COL:  dram_addr = cfg_q.mux ? (addr_q & col_mask) : addr_q;
            default: dram_addr = '0;
        endcase
    end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              ras_n,
    input logic              cas_n,
    input logic              ready,
    input logic              dram_we_n,
    input logic              mux_on,
    input logic [ADDR_W-1:0] dram_addr
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (ras_n && cas_n && dram_we_n && !ready));

    p_cas_under_ras_r8: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    p_ready_single_r9: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    p_ready_at_cas_end_r9: assert property (@(posedge clk) disable iff (rst)
        ready |-> (!cas_n ##1 cas_n));

    p_we_in_page_r11: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> !ras_n);

    p_col_fits_r7: assert property (@(posedge clk) disable iff (rst)
        (mux_on && !cas_n) |-> ((dram_addr >> 10) == '0));
endmodule

bind dram_page_ctrl dpc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .ready     (ready),
    .dram_we_n (dram_we_n),
    .mux_on    (mux_on),
    .dram_addr (dram_addr)
);

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [4:0]    cfg_wdata = '0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          ready, ras_n, cas_n, dram_we_n;
    logic [AW-1:0] dram_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int cyc = 0;

    int lat, ras_hi, cas_lo, we_lo, after_cas, after_rdy;
    logic [AW-1:0] row_a, col_a;

    always #2 clk = ~clk;

    dram_page_ctrl #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_addr(req_addr), .req_write(req_write),
        .ready(ready), .ras_n(ras_n), .cas_n(cas_n),
        .dram_we_n(dram_we_n), .dram_addr(dram_addr)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int split_of(input logic [1:0] code);
        return (code == 2'b00) ? 8 : (code == 2'b01) ? 9 : 10;
    endfunction

    task automatic cfg_write(input logic [4:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [AW-1:0] a, input logic w);
        bit got_row, got_col;
        @(negedge clk);
        req = 1'b1; req_addr = a; req_write = w;
        lat = 0; ras_hi = 0; cas_lo = 0; we_lo = 0;
        got_row = 0; got_col = 0; row_a = '0; col_a = '0;
        do begin
            @(negedge clk);
            lat++;
            if (ras_n) ras_hi++;
            else if (cas_n && !got_row && !got_col) begin row_a = dram_addr; got_row = 1; end
            if (!cas_n) begin
                cas_lo++;
                if (!got_col) begin col_a = dram_addr; got_col = 1; end
            end
            if (!dram_we_n) we_lo++;
        end while (!ready && lat < 100);
        req = 1'b0;
        @(negedge clk);
        after_cas = cas_n;
        after_rdy = ready;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", "ras_n in reset", ras_n, 1);
        chk("R1", "cas_n in reset", cas_n, 1);
        chk("R1", "we_n in reset", dram_we_n, 1);
        chk("R1", "ready in reset", ready, 0);
        rst = 1'b0;
        access(20'h12345, 1'b0);
        chk("R1", "default full access latency", lat, 22);
        chk("R6", "row phase address unmuxed", row_a, 20'h12345);
        chk("R6", "column phase address unmuxed", col_a, 20'h12345);
        chk("R8", "default cas low cycles", cas_lo, 10);
        chk("R9", "cas_n after ready", after_cas, 1);
        chk("R9", "ready single cycle", after_rdy, 0);
    endtask

    task automatic t_no_burst;
        access(20'h12345, 1'b0);
        chk("R2", "repeat row still full", lat, 22);
        chk("R2", "no precharge when closed", ras_hi, 0);
    endtask

    task automatic t_burst;
        cfg_write(5'b10000);
        access(20'h0AB12, 1'b0);
        chk("R2", "first burst access full", lat, 22);
        access(20'h0AB77, 1'b0);
        chk("R3", "same row hit latency", lat, 20);
        chk("R3", "ras held low on hit", ras_hi, 0);
        access(20'h0AC12, 1'b0);
        chk("R4", "miss latency", lat, 24);
        chk("R4", "precharge cycles", ras_hi, 2);
    endtask

    task automatic t_compare_range;
        cfg_write(5'b10000);
        access(20'h00100, 1'b0);
        chk("R10", "after cfg write open page", lat, 24);
        access(20'h00000, 1'b0);
        chk("R5", "bit8 differs at split 8 -> miss", lat, 24);
        cfg_write(5'b10010);
        access(20'h00000, 1'b0);
        access(20'h00300, 1'b0);
        chk("R5", "bits 9:8 differ at split 10 -> hit", lat, 20);
        cfg_write(5'b10001);
        access(20'h00000, 1'b0);
        access(20'h00200, 1'b0);
        chk("R5", "bit9 differs at split 9 -> miss", lat, 24);
        cfg_write(5'b10011);
        access(20'h00000, 1'b0);
        access(20'h003FF, 1'b0);
        chk("R5", "reserved code acts as 10 -> hit", lat, 20);
        access(20'h00400, 1'b0);
        chk("R5", "reserved code bit10 -> miss", lat, 24);
    endtask

    task automatic t_mux;
        logic [AW-1:0] a;
        a = 20'h5A5A5;
        for (int c = 0; c < 4; c++) begin
            int s;
            s = split_of(2'(c));
            cfg_write({3'b001, 2'(c)});
            access(a, 1'b0);
            chk("R7", $sformatf("muxed row code %0d", c), row_a, int'(a >> s));
            chk("R7", $sformatf("muxed col code %0d", c), col_a, int'(a & ((20'd1 << s) - 1)));
        end
    endtask

    task automatic t_duty;
        cfg_write(5'b01000);
        access(20'h00ABC, 1'b0);
        chk("R8", "short high cas low cycles", cas_lo, 13);
        chk("R9", "short duty cas_n after ready", after_cas, 1);
        cfg_write(5'b00000);
        access(20'h00ABC, 1'b0);
        chk("R8", "half duty cas low cycles", cas_lo, 10);
    endtask

    task automatic t_clear;
        cfg_write(5'b10000);
        access(20'h01234, 1'b0);
        chk("R10", "closed page full", lat, 22);
        access(20'h01234, 1'b0);
        chk("R3", "repeat hit", lat, 20);
        cfg_write(5'b10000);
        access(20'h01234, 1'b0);
        chk("R10", "same row after cfg write is full", lat, 24);
        chk("R10", "precharge after cfg write", ras_hi, 2);
    endtask

    task automatic t_write;
        cfg_write(5'b00000);
        access(20'h0F0F0, 1'b1);
        chk("R11", "we low cycles on write", we_lo, 20);
        access(20'h0F0F0, 1'b0);
        chk("R11", "we low cycles on read", we_lo, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_no_burst();
        t_burst();
        t_compare_range();
        t_mux();
        t_duty();
        t_clear();
        t_write();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule